// File: doc/BRIEF.md
# Sticky Level Interrupt Controller

This block gathers a bank of level-sensitive interrupt request lines and presents one combined request to a small processor. Each line is captured on the clock into a live level register. The live levels are merged into a sticky pending register, so a short pulse is still remembered after its line has dropped. A mask register selects which pending bits may reach the processor. The processor reads the mask and pending registers directly from output ports. It replaces the mask with a single write. It clears pending bits by writing ones to the acknowledge port.

Every line also has its own event counter. The counter advances once on each low-to-high transition of that line. Any counter can be read by placing its line number on an index port, and the value appears one clock later. All widths are parameters. The default build has 32 lines and 32-bit counters.

Top module: `sirq_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `mask_q`, `pend_q`, the internal level register and every event counter are zero, and `cpu_irq` is low.
- R2: Input line k maps to bit k of the level, pending and mask registers. A line sampled high at a rising clock edge shows its pending bit set on `pend_q` after that edge.
- R3: A pending bit stays set after its line falls. Cycles without an acknowledge never clear it.
- R4: `cpu_irq` is high exactly when some bit of `pend_q & mask_q` is 1. It follows every input change, mask write and acknowledge in the cycle after the edge that updates those registers.
- R5: An acknowledge (`ack_wr_en` high) clears each pending bit whose bit in `ack_wr_data` is 1. It leaves bits written as 0 unchanged.
- R6: The pending update ORs in the levels sampled at the same edge after applying the acknowledge. A line that is high during an acknowledge therefore stays pending. This includes a line rising in the very cycle its bit is acknowledged.
- R7: A mask write (`mask_wr_en` high) replaces all bits of `mask_q` with `mask_wr_data` at the next edge. Without a write, the mask holds its value.
- R8: A line's counter increments by one on each clock edge at which the line is sampled high after having been sampled low. Holding the line high for many cycles adds only one.
- R9: Counters are CNT_W bits wide and wrap from all ones to zero.
- R10: `cnt_rd_data` shows, one edge after `cnt_idx` is presented, the value the indexed counter held at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Level interrupt request lines |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | NUM_LINES | New mask value |
| ack_wr_en | input | 1 | Acknowledge strobe |
| ack_wr_data | input | NUM_LINES | Ones select pending bits to clear |
| cnt_idx | input | IDX_W | Line number of the counter to read |
| mask_q | output | NUM_LINES | Current mask register |
| pend_q | output | NUM_LINES | Current pending register |
| cnt_rd_data | output | CNT_W | Registered counter read value |
| cpu_irq | output | 1 | Combined interrupt request to the processor |

## Verification
The assertions assume that every input is free of X and Z from the first clock edge after reset is released. They also assume that the request lines are already synchronous to `clk`. The checker only uses `$past` once one full cycle has passed out of reset. The bench drives every input to a known value before reset and changes inputs only on the falling clock edge, half a period away from the sampling edge. It holds all request lines low throughout reset.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int unsigned SIRQ_LINES_DEF = 32;
   localparam int unsigned SIRQ_CNT_W_DEF = 32;

   // index width for a bank of n lines (at least one bit)
   function automatic int unsigned sirq_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit sirq_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/sirq_sampler.sv
module sirq_sampler #(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic [NUM_LINES-1:0] level_q,
   output logic [NUM_LINES-1:0] rise
);
   // live level register: one flop per line
   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q[g] <= 1'b0;
         else        level_q[g] <= irq_in[g];
      end
      // line is high now, was low at the previous edge
      assign rise[g] = irq_in[g] & ~level_q[g];
   end
endmodule

// File: rtl/sirq_pending.sv
module sirq_pending #(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 mask_wr_en,
   input  logic [NUM_LINES-1:0] mask_wr_data,
   input  logic                 ack_wr_en,
   input  logic [NUM_LINES-1:0] ack_wr_data,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] pend_q,
   output logic                 cpu_irq
);
   logic [NUM_LINES-1:0] clr_sel;
   logic [NUM_LINES-1:0] pend_d;
   logic [NUM_LINES-1:0] mask_d;

   always_comb begin
      clr_sel = ack_wr_en ? ack_wr_data : '0;
      // clear first, then merge the live levels so a high line wins
      pend_d  = (pend_q & ~clr_sel) | irq_in;
      mask_d  = mask_wr_en ? mask_wr_data : mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= pend_d;
         mask_q <= mask_d;
      end
   end

   assign cpu_irq = |(pend_q & mask_q);
endmodule

// File: rtl/sirq_counters.sv
module sirq_counters #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned CNT_W     = 32,
   localparam int unsigned IDX_W    = sirq_pkg::sirq_idx_w(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] rise,
   input  logic [IDX_W-1:0]     cnt_idx,
   output logic [CNT_W-1:0]     cnt_rd_data
);
   logic [CNT_W-1:0] cnt_q [NUM_LINES];
   logic [CNT_W-1:0] sel_cnt;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt_q[g] <= '0;
         else if (rise[g]) cnt_q[g] <= cnt_q[g] + 1'b1;   // wraps naturally
      end
   end

   // read selector: a full power-of-two bank needs no range guard
   if (sirq_pkg::sirq_is_pow2(NUM_LINES)) begin : g_sel_full
      assign sel_cnt = cnt_q[cnt_idx];
   end else begin : g_sel_guard
      always_comb begin
         sel_cnt = '0;
         for (int i = 0; i < NUM_LINES; i++)
            if (int'(cnt_idx) == i) sel_cnt = cnt_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_rd_data <= '0;
      else        cnt_rd_data <= sel_cnt;
   end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl #(
   parameter int unsigned NUM_LINES = sirq_pkg::SIRQ_LINES_DEF,
   parameter int unsigned CNT_W     = sirq_pkg::SIRQ_CNT_W_DEF,
   localparam int unsigned IDX_W    = sirq_pkg::sirq_idx_w(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 mask_wr_en,
   input  logic [NUM_LINES-1:0] mask_wr_data,
   input  logic                 ack_wr_en,
   input  logic [NUM_LINES-1:0] ack_wr_data,
   input  logic [IDX_W-1:0]     cnt_idx,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [NUM_LINES-1:0] pend_q,
   output logic [CNT_W-1:0]     cnt_rd_data,
   output logic                 cpu_irq
);
   // elaboration-time parameter checks
   if (NUM_LINES < 2 || NUM_LINES > 32) begin : g_bad_lines
      $error("sirq_ctrl: NUM_LINES must lie in 2..32");
   end
   if (CNT_W < 1 || CNT_W > 64) begin : g_bad_cnt
      $error("sirq_ctrl: CNT_W must lie in 1..64");
   end

   logic [NUM_LINES-1:0] level_q;
   logic [NUM_LINES-1:0] rise;

   sirq_sampler #(.NUM_LINES(NUM_LINES)) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .level_q (level_q),
      .rise    (rise)
   );

   sirq_pending #(.NUM_LINES(NUM_LINES)) u_pending (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_in       (irq_in),
      .mask_wr_en   (mask_wr_en),
      .mask_wr_data (mask_wr_data),
      .ack_wr_en    (ack_wr_en),
      .ack_wr_data  (ack_wr_data),
      .mask_q       (mask_q),
      .pend_q       (pend_q),
      .cpu_irq      (cpu_irq)
   );

   sirq_counters #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_counters (
      .clk         (clk),
      .rst_n       (rst_n),
      .rise        (rise),
      .cnt_idx     (cnt_idx),
      .cnt_rd_data (cnt_rd_data)
   );
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
   parameter int unsigned NUM_LINES = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_in,
   input logic                 mask_wr_en,
   input logic [NUM_LINES-1:0] mask_wr_data,
   input logic                 ack_wr_en,
   input logic [NUM_LINES-1:0] ack_wr_data,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] pend_q,
   input logic                 cpu_irq
);
   // set once a full cycle has passed out of reset, so $past is meaningful
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2: a line high at an edge is pending after it
   a_r2_level_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((pend_q & $past(irq_in)) == $past(irq_in)));

   // R3: bits only fall through an acknowledge
   a_r3_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(ack_wr_en)) |-> (($past(pend_q) & ~pend_q) == '0));

   // R5: acknowledged bits whose line was low are cleared
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(ack_wr_en)) |->
         ((pend_q & $past(ack_wr_data) & ~$past(irq_in)) == '0));

   // R5: bits written as zero are unchanged
   a_r5_ack_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(ack_wr_en)) |->
         ((($past(pend_q) & ~$past(ack_wr_data)) & ~pend_q) == '0));

   // R7: a mask write loads the whole register
   a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_en |=> (mask_q == $past(mask_wr_data)));

   // R7: no write, no change
   a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr_en |=> $stable(mask_q));

   // R4: an empty mask or empty pending set keeps the request low
   a_r4_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0 || pend_q == '0) |-> !cpu_irq);
endmodule

bind sirq_ctrl sirq_checker #(.NUM_LINES(NUM_LINES)) u_sirq_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_in       (irq_in),
   .mask_wr_en   (mask_wr_en),
   .mask_wr_data (mask_wr_data),
   .ack_wr_en    (ack_wr_en),
   .ack_wr_data  (ack_wr_data),
   .mask_q       (mask_q),
   .pend_q       (pend_q),
   .cpu_irq      (cpu_irq)
);

// File: tb/test_sirq_ctrl.sv
`timescale 1ns/1ps
module test_sirq_ctrl;
   localparam int unsigned NL  = 8;
   localparam int unsigned CW  = 4;
   localparam int unsigned IW  = 3;
   localparam int unsigned CNT_MOD = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_in = '0;
   logic          mask_wr_en = 1'b0;
   logic [NL-1:0] mask_wr_data = '0;
   logic          ack_wr_en = 1'b0;
   logic [NL-1:0] ack_wr_data = '0;
   logic [IW-1:0] cnt_idx = '0;
   logic [NL-1:0] mask_q;
   logic [NL-1:0] pend_q;
   logic [CW-1:0] cnt_rd_data;
   logic          cpu_irq;

   always #2.5 clk = ~clk;

   sirq_ctrl #(.NUM_LINES(NL), .CNT_W(CW)) i_sirq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
      .ack_wr_en(ack_wr_en), .ack_wr_data(ack_wr_data),
      .cnt_idx(cnt_idx), .mask_q(mask_q), .pend_q(pend_q),
      .cnt_rd_data(cnt_rd_data), .cpu_irq(cpu_irq)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // bench-side model
   logic [NL-1:0] m_pend = '0;
   logic [NL-1:0] m_mask = '0;
   logic [NL-1:0] m_prev = '0;
   int            m_cnt [NL];

   task automatic chk(input string tag, input longint got, input longint exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   // one clock with the given stimulus; model updated at the edge
   task automatic step(input logic [NL-1:0] in, input logic men, input logic [NL-1:0] md,
                       input logic aen, input logic [NL-1:0] ad);
      @(negedge clk);
      irq_in = in; mask_wr_en = men; mask_wr_data = md;
      ack_wr_en = aen; ack_wr_data = ad;
      @(posedge clk);
      for (int i = 0; i < NL; i++)
         if (in[i] && !m_prev[i]) m_cnt[i] = (m_cnt[i] + 1) % CNT_MOD;
      m_pend = (m_pend & ~(aen ? ad : '0)) | in;
      if (men) m_mask = md;
      m_prev = in;
      @(negedge clk);
      mask_wr_en = 1'b0; ack_wr_en = 1'b0;
   endtask

   task automatic chk_state(input string tag);
      chk({tag, " pend"}, pend_q, m_pend);
      chk({tag, " mask"}, mask_q, m_mask);
      chk({"R4 irq"}, cpu_irq, |(m_pend & m_mask));
   endtask

   // read every counter while holding the inputs steady
   task automatic chk_counters(input string tag);
      for (int i = 0; i < NL; i++) begin
         @(negedge clk);
         cnt_idx = IW'(i);
         @(negedge clk);
         chk({tag, " R10 cnt"}, cnt_rd_data, m_cnt[i]);
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) m_cnt[i] = 0;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1 pend", pend_q, 0);
      chk("R1 mask", mask_q, 0);
      chk("R1 irq", cpu_irq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1");
      chk_counters("R1");

      // R2/R3/R5: every input pattern set, dropped, then fully acknowledged
      for (int p = 0; p < (1 << NL); p++) begin
         step(NL'(p), 0, '0, 0, '0);
         chk_state("R2");
         step('0, 0, '0, 0, '0);
         chk_state("R3");
         step('0, 0, '0, 1, '1);
         chk_state("R5");
      end
      // R8/R9: 128 rises per line wrap a 4-bit counter
      chk_counters("R9");

      // R4/R7: full mask sweep against a fixed pending pattern
      step(8'hA5, 0, '0, 0, '0);
      step('0, 0, '0, 0, '0);
      for (int m = 0; m < (1 << NL); m++) begin
         step('0, 1, NL'(m), 0, '0);
         chk_state("R7");
      end
      step('0, 0, '0, 0, '0);
      chk_state("R7 hold");

      // R5: partial acknowledge leaves zero-written bits alone
      step('0, 1, '1, 1, 8'h0F);
      chk("R5 partial", pend_q, 8'hA0);
      chk_state("R5");

      // R6: acknowledge while lines are high keeps them pending
      step(8'h03, 0, '0, 0, '0);
      step(8'h03, 0, '0, 1, 8'h03);
      chk("R6 held", pend_q & 8'h03, 8'h03);
      chk_state("R6");

      // R6: rise in the same cycle as the acknowledge of that bit
      step('0, 0, '0, 1, '1);
      step(8'h10, 0, '0, 0, '0);
      step('0, 0, '0, 0, '0);
      step(8'h10, 0, '0, 1, 8'h10);
      chk("R6 same cycle", pend_q & 8'h10, 8'h10);
      chk_state("R6");

      // R8: a long-held line counts once
      step('0, 0, '0, 1, '1);
      for (int k = 0; k < 7; k++) step(8'h01, 0, '0, 0, '0);
      chk_counters("R8");
      step('0, 0, '0, 0, '0);
      step(8'h81, 0, '0, 0, '0);
      chk_counters("R8");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule